// File: doc/BRIEF.md
# Timer Control Write-Once Lock Guard

This block holds a timer's safety-related control fields: the dead-time code, break settings, off-state selects, idle levels, output polarities and output-compare settings. A 2-bit protection level decides which of those fields software may still change. The protection level itself takes exactly one write after reset and then stays fixed until the next reset. This stops runaway firmware from changing how power stages are driven.

Software writes through a simple bus with a write strobe, a 2-bit address, 16 data bits and two byte enables. The block has four registers:

- Address 0: dead-time code in bits 7:0; break enable (bit 8), break polarity (bit 9), automatic output enable (bit 10), run-state off select (bit 11), idle-state off select (bit 12) and the protection level in bits 14:13.
- Address 1: idle levels in bits 3:0.
- Address 2: output polarities in bits 3:0. Channel c uses bits 2c and 2c+1.
- Address 3: one byte per channel. In byte c, bits 1:0 are the direction select (00 means output), bit 2 is preload and bits 5:3 are the compare mode.

The field values are driven out continuously, together with one write-permission flag per field group.

Top module: `tim_lock_ctl`

## Requirements
- R1: The first write that carries byte 1 of address 0 loads the protection level from bits 14:13 and sets `lock_frozen`. Every later such write leaves the level unchanged until reset.
- R2: Writing level 00 also uses up the single write. The level then stays 00 and every field stays writable.
- R3: While the level is nonzero, `dead_time` ignores writes.
- R4: While the level is nonzero, `brk_en`, `brk_pol`, `auto_oe` and `idle_lvl` ignore writes.
- R5: At level 10 or 11, `off_run` and `off_idle` ignore writes.
- R6: At level 10 or 11, a channel's polarity bits ignore writes only while that channel's select is 00. A channel whose select is nonzero accepts polarity writes at the same level.
- R7: At level 11, a channel's compare mode and preload ignore writes only while that channel's select is 00.
- R8: Protection is decided from the state before the write. Unprotected fields in the same write are still updated, and the direction select is never protected.
- R9: After reset, every field is 0, the level is 00, `lock_frozen` is 0 and every write-permission flag is 1.
- R10: Each write-permission flag is 1 exactly when a write would change its field group.
- R11: A write changes only the bytes whose byte enable is set. Bits 7:0 use byte enable 0 and bits 15:8 use byte enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte enables |
| lock_level | output | 2 | Current protection level |
| lock_frozen | output | 1 | The protection level has been written |
| dead_time | output | 8 | Dead-time code |
| brk_en | output | 1 | Break enable |
| brk_pol | output | 1 | Break polarity |
| auto_oe | output | 1 | Automatic output enable |
| off_run | output | 1 | Run-state off select |
| off_idle | output | 1 | Idle-state off select |
| idle_lvl | output | 4 | Idle level of each output |
| out_pol | output | 4 | Polarity of each output |
| ch_sel | output | 4 | Per-channel direction select |
| oc_mode | output | 6 | Per-channel compare mode |
| oc_preload | output | 2 | Per-channel preload enable |
| we_dtime | output | 1 | Dead-time code is writable |
| we_brk | output | 1 | Break and automatic-enable bits are writable |
| we_idle | output | 1 | Idle levels are writable |
| we_offsel | output | 1 | Off-state selects are writable |
| we_pol | output | 2 | Per-channel polarity is writable |
| we_occtl | output | 2 | Per-channel compare control is writable |

## Verification
The hold properties take two things for granted: reset is the only way the level returns to 00, and the bus delivers at most one write per cycle. The bench drives one write at a time and returns the strobe low before the next edge. It resets before each new level scenario, because the level can only be set once per reset. The bench changes channel directions both before and after the level is set. This shows that a protected channel becomes writable again when it is switched to input.

// File: rtl/tim_lock_ctl.sv
module tim_lock_ctl #(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [1:0]       wr_be,
  output logic [1:0]       lock_level,
  output logic             lock_frozen,
  output logic [7:0]       dead_time,
  output logic             brk_en,
  output logic             brk_pol,
  output logic             auto_oe,
  output logic             off_run,
  output logic             off_idle,
  output logic [2*NCH-1:0] idle_lvl,
  output logic [2*NCH-1:0] out_pol,
  output logic [2*NCH-1:0] ch_sel,
  output logic [3*NCH-1:0] oc_mode,
  output logic [NCH-1:0]   oc_preload,
  output logic             we_dtime,
  output logic             we_brk,
  output logic             we_idle,
  output logic             we_offsel,
  output logic [NCH-1:0]   we_pol,
  output logic [NCH-1:0]   we_occtl
);
  localparam logic [1:0] A_BRK = 2'd0, A_IDLE = 2'd1, A_POL = 2'd2, A_MODE = 2'd3;
  localparam int IW = 2 * NCH;

  logic lv1, lv2, lv3;
  logic [NCH-1:0] ch_out;
  logic wb_lo, wb_hi, wi_lo, wp_lo;

  assign lv1 = |lock_level;
  assign lv2 = lock_level[1];
  assign lv3 = &lock_level;

  assign we_dtime  = !lv1;
  assign we_brk    = !lv1;
  assign we_idle   = !lv1;
  assign we_offsel = !lv2;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_out[c]   = (ch_sel[2*c +: 2] == 2'b00);
    assign we_pol[c]   = !(lv2 && ch_out[c]);
    assign we_occtl[c] = !(lv3 && ch_out[c]);
  end

  assign wb_lo = wr_en && wr_addr == A_BRK  && wr_be[0];
  assign wb_hi = wr_en && wr_addr == A_BRK  && wr_be[1];
  assign wi_lo = wr_en && wr_addr == A_IDLE && wr_be[0];
  assign wp_lo = wr_en && wr_addr == A_POL  && wr_be[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_level  <= '0;
      lock_frozen <= 1'b0;
      dead_time   <= '0;
      {off_idle, off_run, auto_oe, brk_pol, brk_en} <= '0;
      idle_lvl    <= '0;
    end else begin
      if (wb_lo && we_dtime) dead_time <= wr_data[7:0];
      if (wb_hi) begin
        if (we_brk) {auto_oe, brk_pol, brk_en} <= wr_data[10:8];
        if (we_offsel) {off_idle, off_run} <= wr_data[12:11];
        if (!lock_frozen) begin
          lock_level  <= wr_data[14:13];
          lock_frozen <= 1'b1;
        end
      end
      if (wi_lo && we_idle) idle_lvl <= wr_data[IW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pol    <= '0;
      ch_sel     <= '0;
      oc_mode    <= '0;
      oc_preload <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wp_lo && we_pol[c]) out_pol[2*c +: 2] <= wr_data[2*c +: 2];
        if (wr_en && wr_addr == A_MODE && wr_be[c]) begin
          ch_sel[2*c +: 2] <= wr_data[8*c +: 2];
          if (we_occtl[c]) begin
            oc_preload[c]     <= wr_data[8*c+2];
            oc_mode[3*c +: 3] <= wr_data[8*c+3 +: 3];
          end
        end
      end
    end
  end

  a_r1_frozen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_frozen |=> lock_frozen);
  a_r1_level_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    lock_frozen |=> $stable(lock_level));
  a_r3_dtime_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != 2'b00) |=> $stable(dead_time));
  a_r4_brk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != 2'b00) |=> $stable({brk_en, brk_pol, auto_oe, idle_lvl}));
  a_r5_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_level[1] |=> $stable({off_run, off_idle}));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r6_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_level[1] && ch_sel[2*c +: 2] == 2'b00) |=> $stable(out_pol[2*c +: 2]));
    a_r7_occtl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_level == 2'b11 && ch_sel[2*c +: 2] == 2'b00)
        |=> $stable({oc_mode[3*c +: 3], oc_preload[c]}));
  end
endmodule

// File: tb/tim_lock_ctl_tb.sv
`timescale 1ns/1ps
module tim_lock_ctl_tb;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, wr_be = 0;
  logic [15:0] wr_data = 0;
  logic [1:0] lock_level; logic lock_frozen; logic [7:0] dead_time;
  logic brk_en, brk_pol, auto_oe, off_run, off_idle;
  logic [3:0] idle_lvl, out_pol, ch_sel; logic [5:0] oc_mode; logic [1:0] oc_preload;
  logic we_dtime, we_brk, we_idle, we_offsel; logic [1:0] we_pol, we_occtl;

  tim_lock_ctl #(.NCH(2)) u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [43:0] exp_q[$];
  string req_q[$];

  logic [1:0] m_lock; logic m_frz; logic [7:0] m_dt; logic [4:0] m_b;
  logic [3:0] m_idle, m_pol, m_sel; logic [5:0] m_mode; logic [1:0] m_pre;

  function automatic logic [43:0] expv();
    logic l1, l2, l3; logic [1:0] o, wp, wo;
    l1 = m_lock != 0; l2 = m_lock[1]; l3 = m_lock == 2'b11;
    for (int c = 0; c < 2; c++) begin
      o[c] = m_sel[2*c +: 2] == 0;
      wp[c] = !(l2 && o[c]);
      wo[c] = !(l3 && o[c]);
    end
    return {m_lock, m_frz, m_dt, m_b, m_idle, m_pol, m_sel, m_mode, m_pre,
            !l1, !l1, !l1, !l2, wp, wo};
  endfunction

  function automatic logic [43:0] obsv();
    return {lock_level, lock_frozen, dead_time, off_idle, off_run, auto_oe, brk_pol, brk_en,
            idle_lvl, out_pol, ch_sel, oc_mode, oc_preload,
            we_dtime, we_brk, we_idle, we_offsel, we_pol, we_occtl};
  endfunction

  task automatic model_wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    logic l1, l2, l3; logic [1:0] o;
    l1 = m_lock != 0; l2 = m_lock[1]; l3 = m_lock == 2'b11;
    for (int c = 0; c < 2; c++) o[c] = m_sel[2*c +: 2] == 0;
    case (a)
      2'd0: begin
        if (be[0] && !l1) m_dt = d[7:0];
        if (be[1]) begin
          if (!l1) m_b[2:0] = d[10:8];
          if (!l2) m_b[4:3] = d[12:11];
          if (!m_frz) begin m_lock = d[14:13]; m_frz = 1; end
        end
      end
      2'd1: if (be[0] && !l1) m_idle = d[3:0];
      2'd2: if (be[0]) for (int c = 0; c < 2; c++)
              if (!(l2 && o[c])) m_pol[2*c +: 2] = d[2*c +: 2];
      default: for (int c = 0; c < 2; c++) if (be[c]) begin
        m_sel[2*c +: 2] = d[8*c +: 2];
        if (!(l3 && o[c])) begin
          m_pre[c] = d[8*c+2];
          m_mode[3*c +: 3] = d[8*c+3 +: 3];
        end
      end
    endcase
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be, input string req);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_be = be;
    model_wr(a, d, be);
    @(posedge clk); #1;
    wr_en = 0;
    exp_q.push_back(expv()); req_q.push_back(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_lock = 0; m_frz = 0; m_dt = 0; m_b = 0; m_idle = 0; m_pol = 0;
    m_sel = 0; m_mode = 0; m_pre = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    exp_q.push_back(expv()); req_q.push_back("R9");
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [43:0] e; string r;
      e = exp_q.pop_front(); r = req_q.pop_front();
      checks++;
      if (obsv() !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", r, obsv(), e);
      end
    end
  end

  initial begin
    // R11 byte enables, R2 level 00 permanent
    do_reset();
    wr(0, 16'h0055, 2'b01, "R11");
    wr(0, 16'h1F00, 2'b10, "R2");
    wr(0, 16'h60AA, 2'b11, "R2");
    wr(1, 16'h000F, 2'b01, "R11");
    wr(1, 16'hFF00, 2'b10, "R11");
    // level 01: R8 same-write update, R3, R4, R10
    do_reset();
    wr(0, 16'h2312, 2'b11, "R8");
    wr(0, 16'h1CAA, 2'b11, "R3");
    wr(1, 16'h0005, 2'b01, "R4");
    wr(2, 16'h000F, 2'b01, "R10");
    // level 10: R5, R6
    do_reset();
    wr(3, 16'h0100, 2'b11, "R6");
    wr(0, 16'h4000, 2'b10, "R5");
    wr(2, 16'h000F, 2'b01, "R6");
    wr(0, 16'h1800, 2'b10, "R5");
    wr(3, 16'h003D, 2'b01, "R6");
    wr(2, 16'h0003, 2'b01, "R6");
    // level 11: R7, R8, R1
    do_reset();
    wr(3, 16'h0100, 2'b11, "R7");
    wr(0, 16'h6000, 2'b10, "R7");
    wr(3, 16'h2C2C, 2'b11, "R7");
    wr(3, 16'h002D, 2'b01, "R8");
    wr(3, 16'h002D, 2'b01, "R7");
    wr(0, 16'h2000, 2'b10, "R1");
    wr(0, 16'h00FF, 2'b01, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule